// File: doc/BRIEF.md
# Bit Test and Branch Unit

This block is a datapath slice of a 16-bit processor core. It picks a single bit out of a data word, stores it in a one-bit test/control flag, and resolves the two conditional branches that look at that flag. The rest of the core supplies an already decoded operation class each cycle, along with the operands that operation needs.

Bits are addressed by a 4-bit code counted from the most significant end: code 0 names bit 15 and code 15 names bit 0. The code can come from an immediate field of the instruction. It can also come from the low nibble of the temporary register, so that software can step through several bit positions in a loop.

A test updates the flag on the clock edge at which it is issued. A branch issued in the next cycle already sees the new value. Branch results are registered: a taken strobe lasting one cycle, and the next program counter.

Top module: `bit_branch_unit`

## Requirements
- R1: A synchronous active-high reset drives the flag, the taken strobe and the next program counter to 0.
- R2: Operation code 1 (immediate test) sets the flag, at the issuing edge, to data bit (15 − imm_code_i). For example, code 0xB selects bit 4.
- R3: Operation code 2 (register test) uses only bits [3:0] of treg_i as the code, with the same reversed numbering as R2; bits [15:4] of treg_i have no effect.
- R4: A test operation (code 1 or 2) leaves the taken strobe at 0 and sets the next program counter to pc_i + 1.
- R5: Operation code 3 (branch if flag clear) taken when the flag is 0: taken strobe 1, next program counter = target_i.
- R6: Operation code 4 (branch if flag set) taken when the flag is 1: taken strobe 1, next program counter = target_i.
- R7: A branch whose condition fails, and any code 0 or 5–7 (no operation), gives taken strobe 0 and next program counter = pc_i + 1, wrapping from 0xFFFF to 0x0000.
- R8: Only codes 1 and 2 change the flag; branches and no-operations hold it.
- R9: The taken strobe lasts exactly one cycle per taken branch and falls in the cycle after unless another branch is taken.
- R10: A branch issued in the cycle right after a test resolves on the value that test just wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 3 | Operation class: 0 none, 1 immediate test, 2 register test, 3 branch if flag clear, 4 branch if flag set |
| data_i | input | 16 | Data word under test |
| imm_code_i | input | 4 | Bit code from the instruction field |
| treg_i | input | 16 | Temporary register value; low nibble is the register-form code |
| pc_i | input | 16 | Address of the current instruction |
| target_i | input | 16 | Branch destination |
| flag_o | output | 1 | Test/control flag |
| taken_o | output | 1 | Branch taken strobe, one cycle |
| next_pc_o | output | 16 | Registered next program counter |

## Verification
The hardest case to reach is a test followed at once by a branch that depends on the value the test just wrote. It is also hard to show that the upper bits of the temporary register play no part. Directed tasks issue a test and then a branch on consecutive edges, with no idle cycle in between. They do this with the flag first preset to the opposite value, so a stale read would change the branch outcome. Register-form tests load the upper twelve bits of treg_i with patterns that would select a different bit if they leaked into the code. All sixteen codes are swept with one-hot and inverted one-hot data words in both forms.

// File: rtl/bbu_pkg.sv
package bbu_pkg;

    typedef enum logic [2:0] {
        OPC_NONE     = 3'd0,
        OPC_TEST_IMM = 3'd1,
        OPC_TEST_REG = 3'd2,
        OPC_BR_CLR   = 3'd3,
        OPC_BR_SET   = 3'd4
    } opc_e;

    function automatic logic is_test(input logic [2:0] op);
        return (op == OPC_TEST_IMM) || (op == OPC_TEST_REG);
    endfunction

    function automatic logic is_branch(input logic [2:0] op);
        return (op == OPC_BR_CLR) || (op == OPC_BR_SET);
    endfunction

endpackage

// File: rtl/bbu_code_select.sv
module bbu_code_select #(
    parameter int DATA_W = 16,
    parameter int CODE_W = $clog2(DATA_W)
) (
    input  logic              use_reg_i,
    input  logic [CODE_W-1:0] imm_code_i,
    input  logic [DATA_W-1:0] treg_i,
    output logic [CODE_W-1:0] code_o
);

    // register form keeps only the low code field of the temporary register
    logic [CODE_W-1:0] reg_code;
    assign reg_code = treg_i[CODE_W-1:0];

    always_comb begin
        code_o = use_reg_i ? reg_code : imm_code_i;
    end

endmodule

// File: rtl/bbu_bit_pick.sv
module bbu_bit_pick #(
    parameter int DATA_W = 16,
    parameter int CODE_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              bit_o
);

    localparam int SLOTS = 1 << CODE_W;

    // slot k holds the data bit that code k names (counted from the MSB)
    logic [SLOTS-1:0] by_code;

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        if (k < DATA_W) begin : g_live
            assign by_code[k] = data_i[DATA_W-1-k];
        end else begin : g_pad
            assign by_code[k] = 1'b0;
        end
    end

    assign bit_o = by_code[code_i];

endmodule

// File: rtl/bbu_branch_resolve.sv
module bbu_branch_resolve #(
    parameter int PC_W = 16
) (
    input  logic            br_clr_i,
    input  logic            br_set_i,
    input  logic            flag_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic [PC_W-1:0] target_i,
    output logic            taken_o,
    output logic [PC_W-1:0] next_pc_o
);

    logic [PC_W-1:0] seq_pc;

    always_comb begin
        seq_pc    = pc_i + PC_W'(1);
        taken_o   = (br_clr_i && !flag_i) || (br_set_i && flag_i);
        next_pc_o = taken_o ? target_i : seq_pc;
    end

endmodule

// File: rtl/bit_branch_unit.sv
module bit_branch_unit #(
    parameter int DATA_W = 16,
    parameter int PC_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [3:0]        imm_code_i,
    input  logic [DATA_W-1:0] treg_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [PC_W-1:0]   target_i,
    output logic              flag_o,
    output logic              taken_o,
    output logic [PC_W-1:0]   next_pc_o
);
    import bbu_pkg::*;

    localparam int CODE_W = $clog2(DATA_W);

    typedef struct packed {
        logic            tc;
        logic            taken;
        logic [PC_W-1:0] npc;
    } unit_state_t;

    unit_state_t state_d, state_q;

    logic              op_test, op_reg, op_clr, op_set;
    logic [CODE_W-1:0] sel_code;
    logic              picked_bit;
    logic              br_taken;
    logic [PC_W-1:0]   br_npc;

    always_comb begin
        op_test = is_test(op_i);
        op_reg  = (op_i == OPC_TEST_REG);
        op_clr  = (op_i == OPC_BR_CLR);
        op_set  = (op_i == OPC_BR_SET);
    end

    bbu_code_select #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_code (
        .use_reg_i  (op_reg),
        .imm_code_i (imm_code_i[CODE_W-1:0]),
        .treg_i     (treg_i),
        .code_o     (sel_code)
    );

    bbu_bit_pick #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_pick (
        .data_i (data_i),
        .code_i (sel_code),
        .bit_o  (picked_bit)
    );

    bbu_branch_resolve #(.PC_W(PC_W)) u_br (
        .br_clr_i  (op_clr),
        .br_set_i  (op_set),
        .flag_i    (state_q.tc),
        .pc_i      (pc_i),
        .target_i  (target_i),
        .taken_o   (br_taken),
        .next_pc_o (br_npc)
    );

    always_comb begin
        state_d       = state_q;
        state_d.tc    = op_test ? picked_bit : state_q.tc;
        state_d.taken = br_taken;
        state_d.npc   = br_npc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flag_o    = state_q.tc;
    assign taken_o   = state_q.taken;
    assign next_pc_o = state_q.npc;

endmodule

// File: rtl/bbu_checker.sv
module bbu_checker #(
    parameter int DATA_W = 16,
    parameter int PC_W   = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        op_i,
    input logic [DATA_W-1:0] data_i,
    input logic [3:0]        imm_code_i,
    input logic [DATA_W-1:0] treg_i,
    input logic [PC_W-1:0]   pc_i,
    input logic [PC_W-1:0]   target_i,
    input logic              flag_o,
    input logic              taken_o,
    input logic [PC_W-1:0]   next_pc_o
);
    localparam int CODE_W = $clog2(DATA_W);
    localparam logic [CODE_W-1:0] TOP = CODE_W'(DATA_W - 1);

    logic [CODE_W-1:0] idx_imm, idx_reg;
    logic              want_imm, want_reg;
    logic [PC_W-1:0]   seq_pc;

    always_comb begin
        idx_imm  = TOP - imm_code_i[CODE_W-1:0];
        idx_reg  = TOP - treg_i[CODE_W-1:0];
        want_imm = data_i[idx_imm];
        want_reg = data_i[idx_reg];
        seq_pc   = pc_i + PC_W'(1);
    end

    assert_imm_test_R2: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd1) |=> (flag_o == $past(want_imm)));

    assert_reg_test_R3: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd2) |=> (flag_o == $past(want_reg)));

    assert_test_no_jump_R4: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd1 || op_i == 3'd2) |=> (!taken_o && next_pc_o == $past(seq_pc)));

    assert_br_clr_R5: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd3 && !flag_o) |=> (taken_o && next_pc_o == $past(target_i)));

    assert_br_set_R6: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd4 && flag_o) |=> (taken_o && next_pc_o == $past(target_i)));

    assert_fallthrough_R7: assert property (@(posedge clk) disable iff (rst)
        ((op_i == 3'd3 && flag_o) || (op_i == 3'd4 && !flag_o) || op_i == 3'd0 || op_i > 3'd4)
        |=> (!taken_o && next_pc_o == $past(seq_pc)));

    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(op_i == 3'd1 || op_i == 3'd2) |=> $stable(flag_o));

    assert_strobe_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(taken_o) |-> ($past(op_i) == 3'd3 || $past(op_i) == 3'd4));

endmodule

bind bit_branch_unit bbu_checker #(.DATA_W(DATA_W), .PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_i       (op_i),
    .data_i     (data_i),
    .imm_code_i (imm_code_i),
    .treg_i     (treg_i),
    .pc_i       (pc_i),
    .target_i   (target_i),
    .flag_o     (flag_o),
    .taken_o    (taken_o),
    .next_pc_o  (next_pc_o)
);

// File: tb/bit_branch_unit_tb.sv
module bit_branch_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_i = 3'd0;
    logic [15:0] data_i = '0;
    logic [3:0]  imm_code_i = '0;
    logic [15:0] treg_i = '0;
    logic [15:0] pc_i = '0;
    logic [15:0] target_i = '0;
    logic        flag_o, taken_o;
    logic [15:0] next_pc_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bit_branch_unit u_dut (
        .clk(clk), .rst(rst), .op_i(op_i), .data_i(data_i),
        .imm_code_i(imm_code_i), .treg_i(treg_i), .pc_i(pc_i),
        .target_i(target_i), .flag_o(flag_o), .taken_o(taken_o),
        .next_pc_o(next_pc_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive at the falling edge, sample just after the next rising edge
    task automatic issue(input logic [2:0] op, input logic [15:0] d, input logic [3:0] ic,
                         input logic [15:0] t, input logic [15:0] pc, input logic [15:0] tgt);
        @(negedge clk);
        op_i = op; data_i = d; imm_code_i = ic; treg_i = t; pc_i = pc; target_i = tgt;
        @(posedge clk);
        #1;
    endtask

    task automatic set_flag(input logic v);
        issue(3'd1, v ? 16'h8000 : 16'h0000, 4'd0, 16'h0, 16'h0100, 16'h0);
    endtask

    task automatic t_reset();
        check("R1 flag", flag_o, 0);
        check("R1 taken", taken_o, 0);
        check("R1 npc", next_pc_o, 0);
    endtask

    task automatic t_imm_sweep();
        for (int c = 0; c < 16; c++) begin
            logic [15:0] one = 16'h1 << (15 - c);
            issue(3'd1, one, 4'(c), 16'h0, 16'h0200 + 16'(c), 16'h7777);
            check("R2 one-hot", flag_o, 1);
            check("R4 taken", taken_o, 0);
            check("R4 npc", next_pc_o, 16'h0201 + 16'(c));
            issue(3'd1, ~one, 4'(c), 16'h0, 16'h0300, 16'h7777);
            check("R2 inverted", flag_o, 0);
        end
        issue(3'd1, 16'h0010, 4'hB, 16'h0, 16'h0, 16'h0);
        check("R2 code B is bit 4", flag_o, 1);
    endtask

    task automatic t_reg_sweep();
        for (int c = 0; c < 16; c++) begin
            logic [15:0] one = 16'h1 << (15 - c);
            // upper bits are junk that would name other bits if used
            logic [15:0] t = {12'hA5C ^ 12'(c * 37), 4'(c)};
            issue(3'd2, one, 4'(15 - c), t, 16'h0400, 16'h1);
            check("R3 one-hot", flag_o, 1);
            issue(3'd2, ~one, 4'(15 - c), t, 16'h0400, 16'h1);
            check("R3 inverted", flag_o, 0);
            check("R4 reg npc", next_pc_o, 16'h0401);
        end
    endtask

    task automatic t_branches();
        set_flag(0);
        issue(3'd3, 16'hFFFF, 4'd0, 16'hFFFF, 16'h1000, 16'h2345);
        check("R5 taken", taken_o, 1);
        check("R5 npc", next_pc_o, 16'h2345);
        check("R8 flag after br", flag_o, 0);
        issue(3'd4, 16'hFFFF, 4'd0, 16'hFFFF, 16'h1001, 16'h2345);
        check("R7 set-br on 0 taken", taken_o, 0);
        check("R7 set-br on 0 npc", next_pc_o, 16'h1002);
        set_flag(1);
        issue(3'd4, 16'h0, 4'd0, 16'h0, 16'h1100, 16'h3456);
        check("R6 taken", taken_o, 1);
        check("R6 npc", next_pc_o, 16'h3456);
        issue(3'd3, 16'h0, 4'd0, 16'h0, 16'h1101, 16'h3456);
        check("R7 clr-br on 1 taken", taken_o, 0);
        check("R7 clr-br on 1 npc", next_pc_o, 16'h1102);
        check("R8 flag hold", flag_o, 1);
        for (int o = 5; o < 8; o++) begin
            issue(3'(o), 16'h0, 4'd0, 16'h0, 16'hFFFF, 16'h4444);
            check("R7 nop wrap", next_pc_o, 16'h0000);
            check("R8 nop hold", flag_o, 1);
        end
    endtask

    task automatic t_strobe();
        set_flag(0);
        issue(3'd3, 16'h0, 4'd0, 16'h0, 16'h0010, 16'h0050);
        check("R9 strobe up", taken_o, 1);
        issue(3'd0, 16'h0, 4'd0, 16'h0, 16'h0050, 16'h0090);
        check("R9 strobe down", taken_o, 0);
        check("R9 npc seq", next_pc_o, 16'h0051);
        issue(3'd3, 16'h0, 4'd0, 16'h0, 16'h0051, 16'h0060);
        issue(3'd3, 16'h0, 4'd0, 16'h0, 16'h0060, 16'h0070);
        check("R9 back-to-back", taken_o, 1);
        check("R9 back-to-back npc", next_pc_o, 16'h0070);
    endtask

    task automatic t_test_then_branch();
        set_flag(0);
        issue(3'd1, 16'h0010, 4'hB, 16'h0, 16'h0020, 16'h0);
        issue(3'd4, 16'h0, 4'd0, 16'h0, 16'h0021, 16'h0ABC);
        check("R10 set-br sees new 1", taken_o, 1);
        check("R10 npc", next_pc_o, 16'h0ABC);
        issue(3'd2, 16'hFFFE, 4'd0, 16'hFFFF, 16'h0030, 16'h0);
        issue(3'd3, 16'h0, 4'd0, 16'h0, 16'h0031, 16'h0DEF);
        check("R10 clr-br sees new 0", taken_o, 1);
        check("R10 npc 2", next_pc_o, 16'h0DEF);
    endtask

    task automatic t_midreset();
        set_flag(1);
        issue(3'd4, 16'h0, 4'd0, 16'h0, 16'h0, 16'h0999);
        @(negedge clk); rst = 1'b1; op_i = 3'd0;
        @(posedge clk); #1;
        check("R1 mid flag", flag_o, 0);
        check("R1 mid taken", taken_o, 0);
        check("R1 mid npc", next_pc_o, 0);
        @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst = 1'b0;
        t_imm_sweep();
        t_reg_sweep();
        t_branches();
        t_strobe();
        t_test_then_branch();
        t_midreset();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule